// File: doc/BRIEF.md
# First-Level Translation Table Address Generator

This block works out where the first-level translation descriptor for a 32-bit virtual address sits in memory. It then fetches that word through a simple request and response handshake, and decodes the returned word. It holds three configuration registers, written and read through a small register port: a low-range table base, a high-range table base, and a split control value N that is three bits wide. N has two jobs. It picks which base serves an address, by testing the top N address bits. It also sets how many low bits of the low-range base are cleared before that base is used.

A walk begins when `walk_req` is seen while the block is idle or finished. At that moment the block latches the descriptor address, which is formed from the current register contents and the address bits [31:20]. It also takes a snapshot of the domain rights word on `dom_ctrl`. The block then raises `fetch_req` with the latched address on `fetch_addr` and holds both steady until `fetch_valid` returns the descriptor word. When the word arrives, the block reports four things and holds all of them until the next descriptor arrives:
- the descriptor kind,
- a translation fault flag,
- the domain number,
- the two-bit access rights that the snapshot grants that domain.

The controller has three states:
- IDLE: waiting after reset.
- FETCH: waiting for memory.
- DONE: results valid.

It has four transitions:
- IDLE to FETCH on `walk_req`.
- FETCH to DONE on `fetch_valid`.
- DONE to FETCH on `walk_req`.
- Stay in the current state otherwise.

Top module: `l1_table_addr_gen`

## Requirements
- R1: After reset, `fetch_req` and `walk_done` are 0. N and both bases read as 0. `fetch_req` and `walk_done` are never high together.
- R2: The register port uses the select codes 0 = low base, 1 = high base, 2 = control. A write to control keeps only `cfg_wdata[2:0]` as N. A read of control returns N zero-extended to 32 bits.
- R3: Both base registers read back the full 32-bit value last written. Select code 3 reads as 0, and a write to it changes no register.
- R4: The high base is chosen when `va & ~(32'hFFFFFFFF >> N)` is nonzero, and the low base is chosen otherwise. With N = 0 the low base is always chosen.
- R5: When the high base is chosen, its bits [13:0] are cleared before use.
- R6: When the low base is chosen, it is ANDed with `~(32'h3FFF >> N)`.
- R7: `fetch_addr` equals the masked chosen base ORed with `(va >> 18) & 32'h3FFC`.
- R8: A `walk_req` sampled in IDLE or DONE moves the block to FETCH at that edge. In FETCH, `fetch_req` stays 1 and `fetch_addr` stays stable until `fetch_valid` arrives. A `walk_req` sampled in FETCH is ignored.
- R9: A `fetch_valid` sampled in FETCH moves the block to DONE at that edge. `walk_done` then stays 1, and the results stay unchanged, until the next request. A `fetch_valid` seen outside FETCH is ignored.
- R10: `desc_kind` equals descriptor bits [1:0]. `desc_fault` is 1 exactly when the kind is 0.
- R11: `desc_domain` equals descriptor bits [8:5]. `desc_access` equals `(R >> (2*domain)) & 3`, where R is `dom_ctrl` as sampled with the request.
- R12: The address is formed from the register values at the request edge. Register writes made during FETCH do not change `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 low base, 1 high base, 2 control) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel`, combinational |
| walk_req | input | 1 | Start a descriptor lookup |
| walk_va | input | 32 | Virtual address to look up |
| dom_ctrl | input | 32 | Domain rights word, two bits per domain |
| fetch_req | output | 1 | Memory read request, high in FETCH |
| fetch_addr | output | 32 | Latched descriptor address |
| fetch_data | input | 32 | Returned descriptor word |
| fetch_valid | input | 1 | Descriptor word valid |
| walk_done | output | 1 | Results valid, high in DONE |
| desc_kind | output | 2 | Descriptor kind field |
| desc_fault | output | 1 | Translation fault (kind 0) |
| desc_domain | output | 4 | Domain number from the descriptor |
| desc_access | output | 2 | Access rights granted to that domain |

## Verification
Register reads are combinational, so a read is checked one time step after `cfg_sel` settles. A written value becomes visible after the rising edge that takes the write.

`fetch_req` and `fetch_addr` are due one edge after a sampled `walk_req`. The four results and `walk_done` are due one edge after a sampled `fetch_valid`.

The bench drives every input on the falling edge and samples at the next falling edge. Each check therefore lands half a cycle after the edge that should have produced the value. Held values are checked again at the later falling edges.

// File: rtl/l1ta_pkg.sv
package l1ta_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } walk_state_e;

    localparam logic [1:0] SEL_BASE_LO = 2'd0;
    localparam logic [1:0] SEL_BASE_HI = 2'd1;
    localparam logic [1:0] SEL_SPLIT   = 2'd2;

endpackage

// File: rtl/l1ta_cfg_regs.sv
module l1ta_cfg_regs
    import l1ta_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int SPLIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [VA_W-1:0]    wdata,
    output logic [VA_W-1:0]    rdata,
    output logic [VA_W-1:0]    base_lo_q,
    output logic [VA_W-1:0]    base_hi_q,
    output logic [SPLIT_W-1:0] split_q
);

    localparam int PAD_W = VA_W - SPLIT_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            split_q   <= '0;
        end else if (we) begin
            case (sel)
                SEL_BASE_LO: base_lo_q <= wdata;
                SEL_BASE_HI: base_hi_q <= wdata;
                SEL_SPLIT:   split_q   <= wdata[SPLIT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_BASE_LO: rdata = base_lo_q;
            SEL_BASE_HI: rdata = base_hi_q;
            SEL_SPLIT:   rdata = {{PAD_W{1'b0}}, split_q};
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/l1ta_addr_calc.sv
module l1ta_addr_calc #(
    parameter int VA_W       = 32,
    parameter int SPLIT_W    = 3,
    parameter int SECT_SHIFT = 20,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [VA_W-1:0]    va,
    input  logic [VA_W-1:0]    base_lo,
    input  logic [VA_W-1:0]    base_hi,
    input  logic [SPLIT_W-1:0] split,
    output logic [VA_W-1:0]    entry_addr
);

    localparam int IDX_W   = VA_W - SECT_SHIFT;
    localparam int ALIGN_W = IDX_W + ENTRY_LOG2;
    localparam int HEAD_W  = VA_W - ALIGN_W;
    localparam logic [VA_W-1:0] ALL_ONES  = '1;
    localparam logic [VA_W-1:0] LOW_ONES  = {{HEAD_W{1'b0}}, {ALIGN_W{1'b1}}};

    logic [VA_W-1:0] range_mask;
    logic [VA_W-1:0] lo_keep;
    logic [VA_W-1:0] hi_keep;
    logic [VA_W-1:0] chosen_base;
    logic [VA_W-1:0] index_part;
    logic            take_hi;

    always_comb begin
        range_mask  = ~(ALL_ONES >> split);
        take_hi     = |(va & range_mask);
        lo_keep     = ~(LOW_ONES >> split);
        hi_keep     = ~LOW_ONES;
        chosen_base = take_hi ? (base_hi & hi_keep) : (base_lo & lo_keep);
        index_part  = {{HEAD_W{1'b0}}, va[VA_W-1:SECT_SHIFT], {ENTRY_LOG2{1'b0}}};
        entry_addr  = chosen_base | index_part;
    end

endmodule

// File: rtl/l1ta_desc_decode.sv
module l1ta_desc_decode #(
    parameter int DATA_W  = 32,
    parameter int DOM_W   = 4,
    parameter int DOM_LSB = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_load,
    input  logic                     rsp_load,
    input  logic [(2<<DOM_W)-1:0]    rights_in,
    input  logic [DATA_W-1:0]        desc_in,
    output logic [1:0]               kind,
    output logic                     fault,
    output logic [DOM_W-1:0]         domain,
    output logic [1:0]               access
);

    localparam int RIGHTS_W = 2 << DOM_W;

    logic [RIGHTS_W-1:0] rights_pend_q;
    logic [RIGHTS_W-1:0] rights_act_q;
    logic [DATA_W-1:0]   desc_q;
    logic [DOM_W:0]      pair_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rights_pend_q <= '0;
        end else if (req_load) begin
            rights_pend_q <= rights_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q       <= '0;
            rights_act_q <= '0;
        end else if (rsp_load) begin
            desc_q       <= desc_in;
            rights_act_q <= rights_pend_q;
        end
    end

    always_comb begin
        kind     = desc_q[1:0];
        fault    = (desc_q[1:0] == 2'b00);
        domain   = desc_q[DOM_LSB +: DOM_W];
        pair_idx = {desc_q[DOM_LSB +: DOM_W], 1'b0};
        access   = rights_act_q[pair_idx +: 2];
    end

endmodule

// File: rtl/l1ta_walk_fsm.sv
module l1ta_walk_fsm
    import l1ta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rsp_valid,
    output logic req_load,
    output logic rsp_load,
    output logic mem_req,
    output logic done
);

    walk_state_e state_q;
    walk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_FETCH;
            ST_FETCH: if (rsp_valid) state_d = ST_DONE;
            ST_DONE:  if (start)     state_d = ST_FETCH;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_load = 1'b0;
        rsp_load = 1'b0;
        mem_req  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_load = start;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                rsp_load = rsp_valid;
            end
            ST_DONE: begin
                done     = 1'b1;
                req_load = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/l1_table_addr_gen.sv
module l1_table_addr_gen #(
    parameter int VA_W       = 32,
    parameter int SPLIT_W    = 3,
    parameter int SECT_SHIFT = 20,
    parameter int ENTRY_LOG2 = 2,
    parameter int DOM_W      = 4,
    parameter int DOM_LSB    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [VA_W-1:0]       cfg_wdata,
    output logic [VA_W-1:0]       cfg_rdata,
    input  logic                  walk_req,
    input  logic [VA_W-1:0]       walk_va,
    input  logic [(2<<DOM_W)-1:0] dom_ctrl,
    output logic                  fetch_req,
    output logic [VA_W-1:0]       fetch_addr,
    input  logic [VA_W-1:0]       fetch_data,
    input  logic                  fetch_valid,
    output logic                  walk_done,
    output logic [1:0]            desc_kind,
    output logic                  desc_fault,
    output logic [DOM_W-1:0]      desc_domain,
    output logic [1:0]            desc_access
);

    logic [VA_W-1:0]    base_lo_q;
    logic [VA_W-1:0]    base_hi_q;
    logic [SPLIT_W-1:0] split_q;
    logic [VA_W-1:0]    entry_addr;
    logic [VA_W-1:0]    addr_q;
    logic               req_load;
    logic               rsp_load;

    l1ta_cfg_regs #(
        .VA_W    (VA_W),
        .SPLIT_W (SPLIT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .base_lo_q (base_lo_q),
        .base_hi_q (base_hi_q),
        .split_q   (split_q)
    );

    l1ta_addr_calc #(
        .VA_W       (VA_W),
        .SPLIT_W    (SPLIT_W),
        .SECT_SHIFT (SECT_SHIFT),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_calc (
        .va         (walk_va),
        .base_lo    (base_lo_q),
        .base_hi    (base_hi_q),
        .split      (split_q),
        .entry_addr (entry_addr)
    );

    l1ta_walk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (walk_req),
        .rsp_valid (fetch_valid),
        .req_load  (req_load),
        .rsp_load  (rsp_load),
        .mem_req   (fetch_req),
        .done      (walk_done)
    );

    l1ta_desc_decode #(
        .DATA_W  (VA_W),
        .DOM_W   (DOM_W),
        .DOM_LSB (DOM_LSB)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_load  (req_load),
        .rsp_load  (rsp_load),
        .rights_in (dom_ctrl),
        .desc_in   (fetch_data),
        .kind      (desc_kind),
        .fault     (desc_fault),
        .domain    (desc_domain),
        .access    (desc_access)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (req_load) begin
            addr_q <= entry_addr;
        end
    end

    assign fetch_addr = addr_q;

endmodule

// File: rtl/l1_table_addr_gen_chk.sv
module l1_table_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_sel,
    input logic [31:0] cfg_rdata,
    input logic        walk_req,
    input logic        fetch_req,
    input logic [31:0] fetch_addr,
    input logic        fetch_valid,
    input logic        walk_done,
    input logic [1:0]  desc_kind,
    input logic        desc_fault,
    input logic [3:0]  desc_domain,
    input logic [1:0]  desc_access
);

    // R1
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req, walk_done}));

    // R2
    split_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd2) |-> (cfg_rdata[31:3] == 29'd0));

    // R8
    start_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && walk_req) |=> fetch_req);

    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr)));

    // R9
    fetch_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid) |=> (walk_done && !fetch_req));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && !walk_req) |=> (walk_done && $stable(desc_kind)
            && $stable(desc_domain) && $stable(desc_access)));

    // R10
    fault_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (desc_fault == (desc_kind == 2'b00)));

endmodule

bind l1_table_addr_gen l1_table_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sel     (cfg_sel),
    .cfg_rdata   (cfg_rdata),
    .walk_req    (walk_req),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .walk_done   (walk_done),
    .desc_kind   (desc_kind),
    .desc_fault  (desc_fault),
    .desc_domain (desc_domain),
    .desc_access (desc_access)
);

// File: tb/l1_table_addr_gen_bench.sv
module l1_table_addr_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        walk_req;
    logic [31:0] walk_va;
    logic [31:0] dom_ctrl;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic [31:0] fetch_data;
    logic        fetch_valid;
    logic        walk_done;
    logic [1:0]  desc_kind;
    logic        desc_fault;
    logic [3:0]  desc_domain;
    logic [1:0]  desc_access;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_lo;
    logic [31:0] m_hi;
    int          m_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    l1_table_addr_gen u_l1_table_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .walk_req(walk_req), .walk_va(walk_va), .dom_ctrl(dom_ctrl),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .fetch_valid(fetch_valid),
        .walk_done(walk_done), .desc_kind(desc_kind), .desc_fault(desc_fault),
        .desc_domain(desc_domain), .desc_access(desc_access)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(logic [31:0] va, int n,
                                             logic [31:0] lo, logic [31:0] hi);
        logic [31:0] base;
        if ((va & ~(32'hFFFF_FFFF >> n)) != 0) base = hi & 32'hFFFF_C000;
        else                                   base = lo & ~(32'h0000_3FFF >> n);
        return base | ((va >> 18) & 32'h0000_3FFC);
    endfunction

    task automatic cfg_write(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read_chk(string tag, logic [1:0] sel, logic [31:0] exp);
        cfg_sel = sel;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic walk(logic [31:0] va, logic [31:0] rights, logic [31:0] data,
                        int lat, bit disturb);
        logic [31:0] ea;
        logic [3:0]  dom;
        logic [1:0]  kind;
        ea   = exp_addr(va, m_n, m_lo, m_hi);
        dom  = data[8:5];
        kind = data[1:0];
        @(negedge clk);
        walk_req = 1'b1; walk_va = va; dom_ctrl = rights;
        @(negedge clk);
        walk_req = 1'b0; walk_va = ~va; dom_ctrl = ~rights;
        chk("R8 fetch_req raised", {31'd0, fetch_req}, 32'd1);
        chk("R7 R4 R5 R6 fetch_addr", fetch_addr, ea);
        chk("R9 done low during fetch", {31'd0, walk_done}, 32'd0);
        for (int k = 0; k < lat; k++) begin
            if (disturb) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = ~m_lo;
                walk_req = 1'b1; walk_va = 32'hFFFF_FFFF;
            end
            @(negedge clk);
            cfg_we = 1'b0; walk_req = 1'b0;
            chk("R8 fetch_req held", {31'd0, fetch_req}, 32'd1);
            chk("R12 fetch_addr stable", fetch_addr, ea);
        end
        fetch_data = data; fetch_valid = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_data = ~data;
        chk("R9 walk_done", {31'd0, walk_done}, 32'd1);
        chk("R9 fetch_req dropped", {31'd0, fetch_req}, 32'd0);
        chk("R10 desc_kind", {30'd0, desc_kind}, {30'd0, kind});
        chk("R10 desc_fault", {31'd0, desc_fault}, {31'd0, kind == 2'b00});
        chk("R11 desc_domain", {28'd0, desc_domain}, {28'd0, dom});
        chk("R11 desc_access", {30'd0, desc_access}, (rights >> (2 * dom)) & 32'd3);
        fetch_valid = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R9 done held", {31'd0, walk_done}, 32'd1);
        chk("R9 R8 no refetch", {31'd0, fetch_req}, 32'd0);
        chk("R9 kind held", {30'd0, desc_kind}, {30'd0, kind});
        chk("R9 domain held", {28'd0, desc_domain}, {28'd0, dom});
        if (disturb) cfg_write(2'd0, m_lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        walk_req = 1'b0; walk_va = '0; dom_ctrl = '0;
        fetch_data = '0; fetch_valid = 1'b0;
        m_lo = '0; m_hi = '0; m_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 fetch_req reset", {31'd0, fetch_req}, 32'd0);
        chk("R1 walk_done reset", {31'd0, walk_done}, 32'd0);
        cfg_read_chk("R1 low base reset", 2'd0, 32'd0);
        cfg_read_chk("R1 high base reset", 2'd1, 32'd0);
        cfg_read_chk("R1 split reset", 2'd2, 32'd0);
        rst_n = 1'b1;

        cfg_write(2'd2, 32'hFFFF_FFF5);
        cfg_read_chk("R2 split keeps low bits", 2'd2, 32'd5);
        cfg_write(2'd2, 32'd0);
        cfg_read_chk("R2 split cleared", 2'd2, 32'd0);

        cfg_write(2'd0, 32'hA5A5_FFFF);
        cfg_write(2'd1, 32'h5A5A_3FFF);
        cfg_read_chk("R3 low base readback", 2'd0, 32'hA5A5_FFFF);
        cfg_read_chk("R3 high base readback", 2'd1, 32'h5A5A_3FFF);
        cfg_write(2'd3, 32'h1234_5678);
        cfg_read_chk("R3 unused select reads zero", 2'd3, 32'd0);
        cfg_read_chk("R3 low base untouched", 2'd0, 32'hA5A5_FFFF);
        cfg_read_chk("R3 high base untouched", 2'd1, 32'h5A5A_3FFF);
        cfg_read_chk("R3 split untouched", 2'd2, 32'd0);

        for (int n = 0; n < 8; n++) begin
            m_n  = n;
            m_lo = 32'hA5A5_FFFF ^ (n << 16);
            m_hi = 32'h5A5A_FFFF ^ (n << 24);
            cfg_write(2'd2, n);
            cfg_write(2'd0, m_lo);
            cfg_write(2'd1, m_hi);
            cfg_read_chk("R2 split value", 2'd2, n);
            for (int i = 0; i < 14; i++) begin
                logic [31:0] va;
                logic [31:0] rights;
                logic [31:0] data;
                case (i)
                    0: va = 32'd0;
                    1: va = 32'hFFFF_FFFF;
                    2: va = (n > 0) ? (32'd1 << (32 - n)) : 32'h8000_0000;
                    3: va = (n > 0) ? ((32'd1 << (32 - n)) - 32'd1) : 32'h7FFF_FFFF;
                    default: va = 32'h9E37_79B9 * (i + 16 * n);
                endcase
                rights = 32'h9E37_79B9 ^ (n * 32'h0101_0101) ^ (i << 8);
                data   = 32'hBEEF_0000 | (((i + n) % 16) << 5) | (i % 4);
                walk(va, rights, data, i % 3, (i % 5) == 2);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule